// File: doc/BRIEF.md
# Serial-Mode Bus Mapper for a Link-to-PHY Data Bus

The block sits on the PHY side of an 8-line ULPI data bus and decides, for each operating mode, which lines the PHY drives and what each line carries. In synchronous mode the PHY leaves the bus to the link and releases the direction line. A strobe from the interface-control register moves the bus into low-power mode or into 6-pin full-speed/low-speed serial mode. In serial mode three lines carry the link's transmit controls to a line-driver model. The remaining lines return the single-ended and differential receive bits, the interrupt and one reserved low line.

Both special modes end when the link raises its stop signal. The block then clears the serial-mode register bit itself and goes back to synchronous mode. Entering either mode takes one turnaround cycle. In that cycle the PHY holds the direction line but drives none of the data lines. Receive bits and the interrupt are mapped combinationally, so they stay valid while the interface clock is stopped.

Top module: `ulpi_bus_mapper`

## Requirements
- R1: After reset, dir_o is 0, bus_oe_o is 0, serial_bit_o is 0 and every interrupt status bit is cleared, so irq_o is 0 while irq_src_i is 0.
- R2: A serial_set_i strobe sampled in synchronous mode sets serial_bit_o and dir_o on that edge. For exactly one cycle after that edge bus_oe_o stays 0 (turnaround). From the next edge the serial mapping applies. bus_oe_o is never nonzero while dir_o is 0.
- R3: In serial mode bus_oe_o is 8'hF8. bus_o[3] is irq_o, bus_o[4] is line_dp_i, bus_o[5] is line_dm_i, bus_o[6] is line_diff_i, and bus_o[7] is 0. bus_o is 0 on every lane the PHY does not drive.
- R4: In serial mode bus_i[0] is transmit enable, bus_i[1] is transmit data and bus_i[2] is single-ended zero. With enable high, tx_oe_o is 1 and tx_dp_o/tx_dm_o are data/inverted data, unless single-ended zero is high, which forces both to 0. With enable low, or outside serial mode, tx_oe_o, tx_dp_o and tx_dm_o are all 0.
- R5: stop_i sampled high while dir_o is 1 returns the block to synchronous mode on that edge: dir_o 0, bus_oe_o 0, serial_bit_o 0. stop_i in synchronous mode has no effect.
- R6: A lowpwr_set_i strobe sampled in synchronous mode raises dir_o with the same one-cycle turnaround. In low-power mode bus_oe_o is 8'hFC, bus_o[3] is irq_o and all other lanes read 0.
- R7: If serial_set_i and lowpwr_set_i are sampled on the same edge in synchronous mode, serial mode wins. Both strobes are ignored while dir_o is 1.
- R8: irq_o is the OR over all sources i of ((status[i] or irq_src_i[i]) and irq_en_i[i]). It follows irq_src_i and irq_en_i combinationally.
- R9: A status bit is set by irq_src_i and holds until an irq_clr_i strobe on its bit. If source and clear fall on the same edge, the source wins.
- R10: clk_run_o is 0 in low-power mode and equals clk_keep_i in serial mode. It is 1 in synchronous mode and during turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_set_i | input | 1 | Register write of 1 to the serial-mode bit |
| lowpwr_set_i | input | 1 | Register write requesting low-power mode |
| stop_i | input | 1 | Link stop signal |
| clk_keep_i | input | 1 | Clock-suspend control bit |
| bus_i | input | 8 | Values the link drives on the data lines |
| bus_o | output | 8 | Values the PHY drives on the data lines |
| bus_oe_o | output | 8 | Per-line PHY drive enable |
| dir_o | output | 1 | Bus direction, 1 when the PHY owns the bus |
| serial_bit_o | output | 1 | Current serial-mode register bit |
| clk_run_o | output | 1 | Interface clock must keep running |
| line_dp_i | input | 1 | Single-ended receive from DP |
| line_dm_i | input | 1 | Single-ended receive from DM |
| line_diff_i | input | 1 | Differential receive |
| tx_oe_o | output | 1 | Line driver enable |
| tx_dp_o | output | 1 | Value driven onto DP |
| tx_dm_o | output | 1 | Value driven onto DM |
| irq_src_i | input | NUM_IRQ | Interrupt source events |
| irq_en_i | input | NUM_IRQ | Interrupt enable mask |
| irq_clr_i | input | NUM_IRQ | Per-bit status clear strobe |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Two things can land on the same edge: an interrupt source firing on a status bit and the clear strobe for that bit. A mode-entry strobe can also coincide with stop_i, or with the other entry strobe. The bench runs interrupt sweeps whose source and clear patterns overlap on chosen cycles. It pulses stop_i during turnaround and raises both entry strobes together. It judges every cycle against a reference model of the mode and the sticky status built from the requirements. Under that model the source beats the clear, stop beats entry, and serial beats low power.

// File: rtl/ulpi_map_pkg.sv
package ulpi_map_pkg;
  localparam int BUS_W = 8;
  // lane positions are decoded by the link, so they are fixed
  localparam int LN_TX_EN   = 0;
  localparam int LN_TX_DAT  = 1;
  localparam int LN_TX_SE0  = 2;
  localparam int LN_IRQ     = 3;
  localparam int LN_RX_DP   = 4;
  localparam int LN_RX_DM   = 5;
  localparam int LN_RX_DIFF = 6;
  localparam int LN_RSVD    = 7;

  typedef enum logic [2:0] {
    ST_SYNC     = 3'd0,
    ST_TURN_SER = 3'd1,
    ST_SERIAL   = 3'd2,
    ST_TURN_LP  = 3'd3,
    ST_LOWPWR   = 3'd4
  } map_state_e;
endpackage

// File: rtl/map_mode_fsm.sv
module map_mode_fsm
  import ulpi_map_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_set_i,
  input  logic       lp_set_i,
  input  logic       stop_i,
  output map_state_e state_o,
  output logic       ser_bit_o
);
  map_state_e state_q, state_d;
  logic       bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_SYNC: begin
        if (ser_set_i) begin
          state_d = ST_TURN_SER;
          bit_d   = 1'b1;
        end else if (lp_set_i) begin
          state_d = ST_TURN_LP;
        end
      end
      ST_TURN_SER: begin
        state_d = stop_i ? ST_SYNC : ST_SERIAL;
        if (stop_i) bit_d = 1'b0;
      end
      ST_TURN_LP: state_d = stop_i ? ST_SYNC : ST_LOWPWR;
      ST_SERIAL: begin
        if (stop_i) begin
          state_d = ST_SYNC;
          bit_d   = 1'b0;
        end
      end
      ST_LOWPWR: if (stop_i) state_d = ST_SYNC;
      default: begin
        state_d = ST_SYNC;
        bit_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SYNC;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  assign state_o   = state_q;
  assign ser_bit_o = bit_q;
endmodule

// File: rtl/map_irq_unit.sv
module map_irq_unit #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] src_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | src_i;
  end

  // raw source folded in so the line works with the clock stopped
  assign irq_o = |((status_q | src_i) & en_i);
endmodule

// File: rtl/map_lane_mux.sv
module map_lane_mux
  import ulpi_map_pkg::*;
(
  input  map_state_e       state_i,
  input  logic [2:0]       tx_lanes_i,
  input  logic             irq_i,
  input  logic             dp_i,
  input  logic             dm_i,
  input  logic             diff_i,
  input  logic             clk_keep_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [BUS_W-1:0] bus_oe_o,
  output logic             dir_o,
  output logic             clk_run_o,
  output logic             tx_oe_o,
  output logic             tx_dp_o,
  output logic             tx_dm_o
);
  always_comb begin
    bus_o     = '0;
    bus_oe_o  = '0;
    dir_o     = 1'b0;
    clk_run_o = 1'b1;
    tx_oe_o   = 1'b0;
    tx_dp_o   = 1'b0;
    tx_dm_o   = 1'b0;
    unique case (state_i)
      ST_TURN_SER, ST_TURN_LP: dir_o = 1'b1;
      ST_SERIAL: begin
        dir_o = 1'b1;
        for (int i = LN_IRQ; i < BUS_W; i++) bus_oe_o[i] = 1'b1;
        bus_o[LN_IRQ]     = irq_i;
        bus_o[LN_RX_DP]   = dp_i;
        bus_o[LN_RX_DM]   = dm_i;
        bus_o[LN_RX_DIFF] = diff_i;
        bus_o[LN_RSVD]    = 1'b0;
        clk_run_o = clk_keep_i;
        tx_oe_o   = tx_lanes_i[LN_TX_EN];
        if (tx_lanes_i[LN_TX_EN] && !tx_lanes_i[LN_TX_SE0]) begin
          tx_dp_o = tx_lanes_i[LN_TX_DAT];
          tx_dm_o = ~tx_lanes_i[LN_TX_DAT];
        end
      end
      ST_LOWPWR: begin
        dir_o = 1'b1;
        for (int i = LN_TX_SE0; i < BUS_W; i++) bus_oe_o[i] = 1'b1;
        bus_o[LN_IRQ] = irq_i;
        clk_run_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ulpi_bus_mapper.sv
module ulpi_bus_mapper
  import ulpi_map_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               serial_set_i,
  input  logic               lowpwr_set_i,
  input  logic               stop_i,
  input  logic               clk_keep_i,
  input  logic [7:0]         bus_i,
  output logic [7:0]         bus_o,
  output logic [7:0]         bus_oe_o,
  output logic               dir_o,
  output logic               serial_bit_o,
  output logic               clk_run_o,
  input  logic               line_dp_i,
  input  logic               line_dm_i,
  input  logic               line_diff_i,
  output logic               tx_oe_o,
  output logic               tx_dp_o,
  output logic               tx_dm_o,
  input  logic [NUM_IRQ-1:0] irq_src_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] irq_clr_i,
  output logic               irq_o
);
  map_state_e state;
  logic       irq;
  logic       unused_lanes;

  assign unused_lanes = ^bus_i[7:3];

  map_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_set_i (serial_set_i),
    .lp_set_i  (lowpwr_set_i),
    .stop_i    (stop_i),
    .state_o   (state),
    .ser_bit_o (serial_bit_o)
  );

  map_irq_unit #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src_i),
    .en_i   (irq_en_i),
    .clr_i  (irq_clr_i),
    .irq_o  (irq)
  );

  map_lane_mux u_mux (
    .state_i    (state),
    .tx_lanes_i (bus_i[2:0]),
    .irq_i      (irq),
    .dp_i       (line_dp_i),
    .dm_i       (line_dm_i),
    .diff_i     (line_diff_i),
    .clk_keep_i (clk_keep_i),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .dir_o      (dir_o),
    .clk_run_o  (clk_run_o),
    .tx_oe_o    (tx_oe_o),
    .tx_dp_o    (tx_dp_o),
    .tx_dm_o    (tx_dm_o)
  );

  assign irq_o = irq;
endmodule

// File: rtl/ulpi_bus_mapper_chk.sv
module ulpi_bus_mapper_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stop_i,
  input logic [7:0]         bus_i,
  input logic [7:0]         bus_o,
  input logic [7:0]         bus_oe_o,
  input logic               dir_o,
  input logic               serial_bit_o,
  input logic               tx_oe_o,
  input logic               tx_dp_o,
  input logic               tx_dm_o,
  input logic [NUM_IRQ-1:0] irq_src_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic [NUM_IRQ-1:0] irq_clr_i,
  input logic               irq_o
);
  // R2
  drive_needs_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_oe_o) |-> dir_o);
  // R2
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_o) |-> (bus_oe_o == 8'h00));
  // R5
  stop_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && stop_i) |=> (!dir_o && !serial_bit_o));
  // R7
  set_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && !stop_i) |=> dir_o);
  // R4
  se0_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe_o && bus_i[2]) |-> (!tx_dp_o && !tx_dm_o));
  // R4
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> (!tx_dp_o && !tx_dm_o));
  // R3
  rsvd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o[7] |-> !bus_o[7]);
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_src_i & irq_en_i)) |-> irq_o);
  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (irq_clr_i == '0)) |=> (irq_o || !$stable(irq_en_i)));
endmodule

bind ulpi_bus_mapper ulpi_bus_mapper_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .bus_i        (bus_i),
  .bus_o        (bus_o),
  .bus_oe_o     (bus_oe_o),
  .dir_o        (dir_o),
  .serial_bit_o (serial_bit_o),
  .tx_oe_o      (tx_oe_o),
  .tx_dp_o      (tx_dp_o),
  .tx_dm_o      (tx_dm_o),
  .irq_src_i    (irq_src_i),
  .irq_en_i     (irq_en_i),
  .irq_clr_i    (irq_clr_i),
  .irq_o        (irq_o)
);

// File: tb/tb_ulpi_bus_mapper.sv
`timescale 1ns/1ps
module tb_ulpi_bus_mapper;
  localparam int NI = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic serial_set = 0, lowpwr_set = 0, stop = 0, clk_keep = 0;
  logic [7:0] bus_in = '0, bus_out, bus_oe;
  logic dir, ser_bit, clk_run, dp = 0, dm = 0, diff = 0, tx_oe, tx_dp, tx_dm, irq;
  logic [NI-1:0] src = '0, en = '0, clr = '0;

  ulpi_bus_mapper #(.NUM_IRQ(NI)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .serial_set_i(serial_set), .lowpwr_set_i(lowpwr_set),
    .stop_i(stop), .clk_keep_i(clk_keep), .bus_i(bus_in), .bus_o(bus_out),
    .bus_oe_o(bus_oe), .dir_o(dir), .serial_bit_o(ser_bit), .clk_run_o(clk_run),
    .line_dp_i(dp), .line_dm_i(dm), .line_diff_i(diff), .tx_oe_o(tx_oe),
    .tx_dp_o(tx_dp), .tx_dm_o(tx_dm), .irq_src_i(src), .irq_en_i(en),
    .irq_clr_i(clr), .irq_o(irq));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // model: 0 sync, 1 turn to serial, 2 serial, 3 turn to low power, 4 low power
  int m_st = 0;
  logic m_bit = 0;
  logic [NI-1:0] m_stat = '0;

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    m_stat = (m_stat & ~clr) | src;
    case (m_st)
      0: if (serial_set) begin m_st = 1; m_bit = 1; end
         else if (lowpwr_set) m_st = 3;
      1: if (stop) begin m_st = 0; m_bit = 0; end else m_st = 2;
      3: m_st = stop ? 0 : 4;
      2: if (stop) begin m_st = 0; m_bit = 0; end
      4: if (stop) m_st = 0;
      default: m_st = 0;
    endcase
  endtask

  task automatic check_all(string tag);
    logic e_irq, e_tdp, e_tdm, e_toe, e_clk;
    logic [7:0] e_bus, e_oe;
    e_irq = |((m_stat | src) & en);
    e_bus = 8'h00; e_oe = 8'h00; e_clk = 1;
    e_toe = 0; e_tdp = 0; e_tdm = 0;
    if (m_st == 2) begin
      e_oe = 8'hF8;
      e_bus = {1'b0, diff, dm, dp, e_irq, 3'b000};
      e_clk = clk_keep;
      e_toe = bus_in[0];
      if (bus_in[0] && !bus_in[2]) begin e_tdp = bus_in[1]; e_tdm = ~bus_in[1]; end
    end else if (m_st == 4) begin
      e_oe = 8'hFC;
      e_bus = {4'h0, e_irq, 3'b000};
      e_clk = 0;
    end
    cmp({tag, "/R2"}, "dir", {7'd0, dir}, {7'd0, (m_st != 0)});
    cmp({tag, "/R2"}, "oe", bus_oe, e_oe);
    cmp({tag, (m_st == 4) ? "/R6" : "/R3"}, "bus", bus_out, e_bus);
    cmp({tag, "/R4"}, "tx", {5'd0, tx_oe, tx_dp, tx_dm}, {5'd0, e_toe, e_tdp, e_tdm});
    cmp({tag, "/R8"}, "irq", {7'd0, irq}, {7'd0, e_irq});
    cmp({tag, "/R5"}, "serial_bit", {7'd0, ser_bit}, {7'd0, m_bit});
    cmp({tag, "/R10"}, "clk_run", {7'd0, clk_run}, {7'd0, e_clk});
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    #2;
    check_all(tag);
  endtask

  task automatic pulse_serial(string tag);
    serial_set = 1; cyc(tag); serial_set = 0;
  endtask

  task automatic pulse_lowpwr(string tag);
    lowpwr_set = 1; cyc(tag); lowpwr_set = 0;
  endtask

  task automatic pulse_stop(string tag);
    stop = 1; cyc(tag); stop = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    en = '1;
    #22;
    check_all("R1");   // in reset
    rst_ni = 1;
    cyc("R1");
    cyc("R1");

    pulse_stop("R5");          // ignored in sync mode
    cyc("R5");

    // serial entry with turnaround, clock not kept
    pulse_serial("R2");
    cyc("R2");
    cyc("R10");
    clk_keep = 1;
    cyc("R10");

    // lane sweep: transmit controls x receive lines
    for (int k = 0; k < 64; k++) begin
      bus_in = {5'b10110, k[2:0]};
      {diff, dm, dp} = k[5:3];
      cyc("R3_R4");
    end

    // interrupt sweep with overlapping source and clear
    for (int k = 0; k < 96; k++) begin
      en  = k[3:0] ^ k[6:3];
      src = (k % 3 == 0) ? NI'((k * 5) % 16) : '0;
      clr = (k % 4 == 1) ? '1 : ((k % 7 == 0) ? NI'(k % 16) : '0);
      cyc("R8_R9");
    end
    src = '0; clr = '0; en = '1;
    cyc("R9");

    // strobes ignored while the PHY owns the bus
    pulse_lowpwr("R7");
    pulse_serial("R7");
    cyc("R7");

    pulse_stop("R5");
    cyc("R5");

    // both strobes together: serial wins
    serial_set = 1; lowpwr_set = 1; cyc("R7");
    serial_set = 0; lowpwr_set = 0;
    cyc("R7");
    pulse_stop("R5");

    // stop during turnaround
    pulse_serial("R2");
    pulse_stop("R5");
    cyc("R5");

    // low-power mode
    clr = '1; cyc("R9"); clr = '0;
    pulse_lowpwr("R6");
    cyc("R6");
    for (int k = 0; k < 32; k++) begin
      bus_in = 8'(k * 37);
      {diff, dm, dp} = k[2:0];
      en  = k[4:1];
      src = (k % 5 == 2) ? NI'(k % 16) : '0;
      clr = (k % 6 == 3) ? '1 : '0;
      cyc("R6_R10");
    end
    src = '0; clr = '0;
    pulse_stop("R5");
    cyc("R5");
    pulse_lowpwr("R6");
    pulse_stop("R6");
    cyc("R6");

    done = 1;
    finish_run();
  end
endmodule